// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous memory that serves four-word bursts. At the start of a burst it captures a 15-bit address. As the burst continues, it steps only the two lowest address bits. The upper bits stay where they were loaded. A static order-select input picks how the low bits advance:

- **Linear order:** the low bits count upward and wrap at four.
- **Interleaved order:** the low bits are the loaded low bits XORed with the number of steps taken so far.

A burst can be started from either of two active-low address strobes. The processor-side strobe is honoured only while the primary chip enable is active. The controller-side strobe always loads. Between strobes, an active-low step input moves the burst forward by one word on each rising edge where it is asserted.

All captures happen on the rising clock edge, so a new address appears on the output just after the edge that sampled it. The order select is not registered. It reshapes the low output bits in the same cycle it changes.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the loaded address and the step count are cleared, so `word_addr` reads 0 after that edge.
- R2: A low `ctrl_strb_n` at a rising edge loads `addr_in` and clears the step count, whatever `chip_en_n` is. `word_addr` equals `addr_in` after that edge.
- R3: A low `proc_strb_n` together with a low `chip_en_n` at a rising edge loads `addr_in` and clears the step count.
- R4: A low `proc_strb_n` while `chip_en_n` is high (and `ctrl_strb_n`, `step_n` high) is ignored: `word_addr` keeps its value.
- R5: With no load, a low `step_n` at a rising edge advances the 2-bit step count by one. A high `step_n` leaves `word_addr` unchanged.
- R6: When `order_sel` is 0 (linear), `word_addr[1:0]` = (loaded bits [1:0] + step count) mod 4. For example, a start of 2 gives 2,3,0,1.
- R7: When `order_sel` is 1 (interleaved), `word_addr[1:0]` = loaded bits [1:0] XOR step count. For example, a start of 1 gives 1,0,3,2.
- R8: `word_addr[14:2]` never changes without a load. A fourth step brings the low bits back to their starting value.
- R9: When a load and a low `step_n` arrive at the same edge, the load wins and the step count becomes 0.
- R10: A load in the middle of a burst replaces the whole address and restarts the step count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_strb_n | input | 1 | Processor-side address strobe, active low, gated by chip enable |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low, ungated |
| chip_en_n | input | 1 | Primary chip enable, active low; qualifies the processor strobe |
| step_n | input | 1 | Burst advance request, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (tie high for interleaved) |
| addr_in | input | 15 | Address captured on a load |
| word_addr | output | 15 | Current word address |

## Verification
A strobe, a step or a reset takes effect at the rising edge that samples it. The output shows the new address after that same edge, one register stage with no further delay. `order_sel` changes the low two bits within the cycle, because it acts combinationally.

For each cycle, the driver sets the inputs on the falling edge. After the following rising edge it queues the expected address computed from the requirements. The monitor compares one queue entry per cycle, a quarter period after each rising edge. At that moment no input is changing, so the comparison can only see the settled post-edge value.

// File: rtl/burst_seq_pkg.sv
// Package: shared constants and types for the burst address sequencer.
// Assumes: one order-select encoding is used by every module of the block.
package burst_seq_pkg;

    // Burst order encoding as seen on the order-select input.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Default sizes of the block.
    localparam int DEF_ADDR_W = 15;
    localparam int DEF_CNT_W  = 2;

endpackage

// File: rtl/bsq_load_ctrl.sv
// Module: decides, per cycle, whether the address is reloaded or the
// burst counter advances. Load always has priority over a step.
// Assumes: all inputs are synchronous to clk and sampled at its rising edge.
module bsq_load_ctrl (
    input  logic proc_strb_n,
    input  logic ctrl_strb_n,
    input  logic chip_en_n,
    input  logic step_n,
    output logic load,
    output logic advance
);

    logic proc_ok;
    logic ctrl_ok;

    // Qualify each strobe: the processor strobe needs the chip enable.
    always_comb begin
        proc_ok = !proc_strb_n && !chip_en_n;
        ctrl_ok = !ctrl_strb_n;
    end

    // Combine strobes into a load; a step only counts without a load.
    always_comb begin
        load    = proc_ok || ctrl_ok;
        advance = !load && !step_n;
    end

    // R9: a load and an advance are never granted in the same cycle.
    always_comb begin
        AST_LOAD_EXCLUSIVE: assert (!(load && advance)); // R9
    end

endmodule

// File: rtl/bsq_base_reg.sv
// Module: holds the address captured at the start of a burst.
// Assumes: load is already qualified; reset is synchronous, active low.
module bsq_base_reg #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q
);

    // Capture the external address on a load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (load)
            base_q <= addr_in;
    end

    // R2: a load puts the sampled address into the base register.
    AST_BASE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (base_q == $past(addr_in))); // R2

    // R8: without a load the base register holds.
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(base_q)); // R8

endmodule

// File: rtl/bsq_wrap_counter.sv
// Module: counts burst steps modulo 2**CNT_W; cleared on every load.
// Assumes: load and advance are mutually exclusive (load wins upstream).
module bsq_wrap_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Clear on reset or load, step by one on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= '0;
        else if (advance)
            cnt_q <= cnt_q + ONE;
    end

    // R10: every load restarts the burst count.
    AST_LOAD_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0)); // R10

    // R5: an advance moves the count by exactly one, wrapping.
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (cnt_q == CNT_W'($past(cnt_q) + ONE))); // R5

    // R5: with neither load nor advance the count holds.
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/bsq_order_map.sv
// Module: maps the base low bits and the burst count onto the output low
// bits in linear (sum) or interleaved (XOR) order.
// Assumes: order_sel is quasi-static; it acts combinationally.
module bsq_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] base_lo,
    input  logic [CNT_W-1:0] cnt,
    input  logic             order_sel,
    output logic [CNT_W-1:0] low_out
);

    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] ilv_lo;

    // Linear order: add the count, wrapping at 2**CNT_W.
    always_comb begin
        lin_lo = base_lo + cnt;
    end

    // Interleaved order: flip each base bit where the count has a one.
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_lo[b] = base_lo[b] ^ cnt[b];
    end

    // Pick the order requested on order_sel.
    always_comb begin
        if (burst_order_e'(order_sel) == ORD_INTERLEAVE)
            low_out = ilv_lo;
        else
            low_out = lin_lo;
    end

    // R6, R7: the first word of a burst is the loaded word in either order.
    always_comb begin
        AST_FIRST_WORD: assert (cnt != '0 || low_out == base_lo); // R6 R7
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer. Captures a burst start
// address on either strobe and walks the low bits through a four-word
// burst in linear or interleaved order.
// Assumes: synchronous active-low reset; all controls sampled on clk rise.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              chip_en_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr
);

    localparam int HI_W = ADDR_W - CNT_W;

    logic              load;
    logic              advance;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  low_bits;

    bsq_load_ctrl u_ctrl (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .chip_en_n   (chip_en_n),
        .step_n      (step_n),
        .load        (load),
        .advance     (advance)
    );

    bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .base_q  (base_q)
    );

    bsq_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .cnt_q   (cnt_q)
    );

    bsq_order_map #(.CNT_W(CNT_W)) u_map (
        .base_lo   (base_q[CNT_W-1:0]),
        .cnt       (cnt_q),
        .order_sel (order_sel),
        .low_out   (low_bits)
    );

    // Assemble the word address: fixed upper part, sequenced low part.
    always_comb begin
        word_addr = {base_q[ADDR_W-1:CNT_W], low_bits};
    end

    // R1: reset leaves the output at address zero.
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (word_addr == '0)); // R1

    // R4: a processor strobe without chip enable does not disturb the base.
    AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && chip_en_n && ctrl_strb_n && step_n) |=> $stable(base_q)); // R4

    // R3: a qualified processor strobe loads the address.
    AST_PROC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && !chip_en_n) |=> (base_q == $past(addr_in))); // R3

    // R8: upper address bits only move on a strobe.
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strb_n && ctrl_strb_n) |=> $stable(word_addr[ADDR_W-1:CNT_W])); // R8

    // R9: a strobe that coincides with a step still starts at count zero.
    AST_STROBE_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strb_n && !step_n) |=> (cnt_q == '0)); // R9

    // R2: the controller strobe loads regardless of chip enable.
    AST_CTRL_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_strb_n |=> (base_q[HI_W+CNT_W-1:0] == $past(addr_in))); // R2

endmodule

// File: tb/burst_addr_seq_tb_top.sv
// Bench: scoreboard for the burst address sequencer. A driver task applies
// one cycle of stimulus, updates a reference model written from the
// requirements and queues the expected address; a monitor compares.
module burst_addr_seq_tb_top;

    localparam int AW = 15;
    localparam time HALF = 10ns;

    typedef struct {
        logic [AW-1:0] exp;
        string         req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          proc_strb_n = 1'b1;
    logic          ctrl_strb_n = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          step_n = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] word_addr;

    item_t         sb_q[$];
    int            n_checks = 0;
    int            n_fail = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    burst_addr_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .chip_en_n   (chip_en_n),
        .step_n      (step_n),
        .order_sel   (order_sel),
        .addr_in     (addr_in),
        .word_addr   (word_addr)
    );

    // 50 MHz clock.
    always #HALF clk = ~clk;

    // Apply one cycle of inputs, step the model, queue the expected address.
    task automatic drive(input logic rst, input logic pn, input logic cn,
                         input logic ce, input logic sn, input logic ord,
                         input logic [AW-1:0] a, input string req);
        item_t it;
        logic [1:0] lo;
        @(negedge clk);
        rst_n = rst; proc_strb_n = pn; ctrl_strb_n = cn;
        chip_en_n = ce; step_n = sn; order_sel = ord; addr_in = a;
        @(posedge clk);
        #1;
        if (!rst) begin
            m_base = '0; m_cnt = '0;
        end else if (!cn || (!pn && !ce)) begin
            m_base = a; m_cnt = '0;
        end else if (!sn) begin
            m_cnt = m_cnt + 2'd1;
        end
        lo = ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        it.exp = {m_base[AW-1:2], lo};
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: a quarter period after each edge, compare one queued item.
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (word_addr !== it.exp) begin
                n_fail++;
                $display("FAIL %s: word_addr=%h expected=%h", it.req, word_addr, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(HALF * 2 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        repeat (2) drive(1'b0, 1, 1, 1, 1, 1, 15'h7FFF, "R1 reset");
        drive(1, 1, 1, 1, 1, 1, 15'h1111, "R1 idle after reset");
        // R2 controller strobe loads with chip enable off, linear order.
        drive(1, 1, 0, 1, 1, 0, 15'h1232, "R2 ctrl load");
        // R6 linear walk 2,3,0,1 then R8 wrap back to 2.
        drive(1, 1, 1, 1, 0, 0, 15'h0000, "R6 linear step1");
        drive(1, 1, 1, 1, 0, 0, 15'h0000, "R6 linear step2");
        drive(1, 1, 1, 1, 0, 0, 15'h0000, "R6 linear step3");
        drive(1, 1, 1, 1, 0, 0, 15'h0000, "R8 wrap to start");
        // R5 hold without step.
        drive(1, 1, 1, 1, 1, 0, 15'h4444, "R5 hold");
        // R3 processor strobe with chip enable, interleaved from 1.
        drive(1, 0, 1, 0, 1, 1, 15'h5A5D, "R3 proc load");
        drive(1, 1, 1, 1, 0, 1, 15'h0000, "R7 interleave step1");
        drive(1, 1, 1, 1, 0, 1, 15'h0000, "R7 interleave step2");
        drive(1, 1, 1, 1, 0, 1, 15'h0000, "R7 interleave step3");
        drive(1, 1, 1, 1, 0, 1, 15'h0000, "R8 interleave wrap");
        // R4 processor strobe without chip enable is ignored.
        drive(1, 0, 1, 1, 1, 1, 15'h7FFF, "R4 proc ignored");
        drive(1, 0, 1, 1, 1, 0, 15'h0F0F, "R4 proc ignored linear view");
        // R9 strobe and step together: load wins.
        drive(1, 1, 0, 1, 0, 0, 15'h0003, "R9 strobe beats step");
        drive(1, 1, 1, 1, 0, 0, 15'h0000, "R6 linear wrap 3->0");
        // R10 reload mid-burst restarts count.
        drive(1, 0, 1, 0, 1, 1, 15'h2AAA, "R10 mid-burst reload");
        drive(1, 1, 1, 1, 0, 1, 15'h0000, "R7 interleave from 2");
        drive(1, 1, 1, 1, 1, 0, 15'h0000, "R6 order switch live");
        repeat (2) @(posedge clk);
        #8;
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard drain: left=%0d expected=0", sb_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule